// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM with 64 words of 16 bits. A host drives chip select, a serial clock and serial data in. The block watches these lines with its own system clock, finds the rising edges of the serial clock, and assembles a frame. A frame is a start bit, a two-bit opcode, a six-bit address and, for the two program instructions that carry a word, sixteen data bits. Read data and program-cycle status come back on one serial data-out line, which has a separate output enable that models high impedance.

Programming is guarded by a write-enable latch that is cleared at reset. Every instruction that changes the array starts a self-timed program cycle. The length of that cycle is a parameter counted in system clock cycles. While the cycle runs, a host that holds chip select high sees busy or ready on data out. The array contents change when the cycle ends.

Top module: `eeprom3w`

## Requirements
- R1: During and after reset, data out is not driven (`do_en_o` low), every word of the array reads 16'hFFFF, and the write-enable latch is clear.
- R2: A frame begins only on the first serial clock rising edge at which chip select and data in are both high. Edges with data in low, and edges with chip select low, start nothing.
- R3: After the start bit, the next two bits are the opcode and the next six bits are the address, most significant bit first. Opcode 2'b10 is a read. After the eighth bit the block drives a 0, and on each of the next 16 rising edges it drives the next bit of the addressed word, bit 15 first. `do_en_o` stays high during this.
- R4: With the write-enable latch clear, the opcodes for word write (2'b01), word erase (2'b11), erase-all (2'b00 with address bits [5:4]=2'b10) and write-all (2'b00 with [5:4]=2'b01) leave the array unchanged and start no program cycle.
- R5: Opcode 2'b00 with address bits [5:4]=2'b11 sets the write-enable latch. With [5:4]=2'b00 it clears the latch.
- R6: Word write (opcode 2'b01 followed by 16 data bits, bit 15 first) replaces the addressed word with the data, whatever it held before.
- R7: Word erase sets the addressed word to 16'hFFFF. Erase-all sets every word to 16'hFFFF.
- R8: Write-all (16 data bits follow the address) replaces every word with the bitwise AND of the word and the data. It does not erase first.
- R9: A program cycle starts once the last required bit has been taken in and lasts PROG_CYCLES system clocks. While chip select is high after the cycle starts, `do_en_o` is high and `do_o` is 0 while busy and 1 once ready. With chip select low, `do_en_o` is low.
- R10: Chip select low before the last bit of a frame discards the frame. This includes chip select falling in the same system clock cycle as the final rising edge.
- R11: After the last bit of a frame, further clock edges with data in low change nothing, until a new start bit arrives.
- R12: A start bit seen while a program cycle is busy is ignored, so the whole frame that follows has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_en_o | output | 1 | Data out enable; low means high impedance |

## Verification
The delicate coincidence is chip select falling in the same system clock cycle as the serial clock edge that carries the last data bit of a word write. Both lines pass through the same synchronizer, so the frame logic sees them together, and the release must win. The bench changes both lines in one drive step. It then checks that raising chip select again shows no busy status, and that a later read returns the word's earlier value. A second overlap is a new start bit arriving while a program cycle runs: an erase frame sent during the busy window must leave the word as it was.

// File: rtl/eeprom3w_pkg.sv
package eeprom3w_pkg;
  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WRITE,
    CMD_ERASE,
    CMD_ERAL,
    CMD_WRAL,
    CMD_WREN,
    CMD_WRDIS
  } cmd_e;

  function automatic logic cmd_programs(cmd_e c);
    return (c == CMD_WRITE) || (c == CMD_ERASE) || (c == CMD_ERAL) || (c == CMD_WRAL);
  endfunction
endpackage

// File: rtl/eeprom3w_sync.sv
module eeprom3w_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [W-1:0] st_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q[0] <= '0;
        else         st_q[0] <= d_i;
      end
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) st_q[s] <= '0;
          else         st_q[s] <= st_q[s-1];
        end
      end
      assign q_o = st_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eeprom3w_frame.sv
module eeprom3w_frame
  import eeprom3w_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              sk_i,
  input  logic              di_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_o,
  output logic              cmd_valid_o,
  output cmd_e              cmd_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_drive_o,
  output logic              rd_bit_o,
  output logic              idle_o
);
  localparam int HDR_W = 2 + ADDR_W;
  localparam int CNT_W = $clog2(DATA_W + 1);

  typedef enum logic [1:0] {F_IDLE, F_HDR, F_DATA, F_READ} fstate_e;

  fstate_e           st_q;
  logic              sk_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] rd_sh_q;

  logic              rise, read_done, start_hit;
  logic [HDR_W-1:0]  hdr_next;
  logic [1:0]        op, sub;
  logic [DATA_W-1:0] rd_word;

  assign rise      = sk_i & ~sk_q;
  assign read_done = (st_q == F_READ) && (cnt_q == CNT_W'(DATA_W));
  assign start_hit = di_i & ~busy_i & ((st_q == F_IDLE) || read_done);
  assign hdr_next  = {hdr_q[HDR_W-2:0], di_i};
  assign op        = hdr_next[HDR_W-1 -: 2];
  assign sub       = hdr_next[ADDR_W-1 -: 2];
  assign rd_word   = (cnt_q == '0) ? rdata_i : rd_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= F_IDLE;
      sk_q        <= 1'b0;
      cnt_q       <= '0;
      hdr_q       <= '0;
      rd_sh_q     <= '0;
      addr_o      <= '0;
      wdata_o     <= '0;
      cmd_o       <= CMD_NONE;
      cmd_valid_o <= 1'b0;
      start_o     <= 1'b0;
      rd_bit_o    <= 1'b0;
    end else begin
      sk_q        <= sk_i;
      start_o     <= 1'b0;
      cmd_valid_o <= 1'b0;
      if (!cs_i) begin
        st_q <= F_IDLE;
      end else if (rise) begin
        unique case (st_q)
          F_IDLE: begin
            if (start_hit) begin
              st_q    <= F_HDR;
              cnt_q   <= '0;
              start_o <= 1'b1;
            end
          end
          F_HDR: begin
            hdr_q <= hdr_next;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(HDR_W - 1)) begin
              cnt_q  <= '0;
              addr_o <= hdr_next[ADDR_W-1:0];
              st_q   <= F_IDLE;
              unique case (op)
                2'b10: begin
                  st_q     <= F_READ;
                  rd_bit_o <= 1'b0;  // dummy zero
                end
                2'b01: begin
                  cmd_o <= CMD_WRITE;
                  st_q  <= F_DATA;
                end
                2'b11: begin
                  cmd_o       <= CMD_ERASE;
                  cmd_valid_o <= 1'b1;
                end
                default: begin
                  unique case (sub)
                    2'b11: begin cmd_o <= CMD_WREN;  cmd_valid_o <= 1'b1; end
                    2'b00: begin cmd_o <= CMD_WRDIS; cmd_valid_o <= 1'b1; end
                    2'b10: begin cmd_o <= CMD_ERAL;  cmd_valid_o <= 1'b1; end
                    default: begin
                      cmd_o <= CMD_WRAL;
                      st_q  <= F_DATA;
                    end
                  endcase
                end
              endcase
            end
          end
          F_DATA: begin
            wdata_o <= {wdata_o[DATA_W-2:0], di_i};
            cnt_q   <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              cmd_valid_o <= 1'b1;
              st_q        <= F_IDLE;
            end
          end
          F_READ: begin
            if (!read_done) begin
              rd_bit_o <= rd_word[DATA_W-1];
              rd_sh_q  <= {rd_word[DATA_W-2:0], 1'b0};
              cnt_q    <= cnt_q + 1'b1;
            end else if (start_hit) begin
              st_q    <= F_HDR;
              cnt_q   <= '0;
              start_o <= 1'b1;
            end else begin
              st_q <= F_IDLE;
            end
          end
          default: st_q <= F_IDLE;
        endcase
      end
    end
  end

  assign rd_drive_o = (st_q == F_READ);
  assign idle_o     = (st_q == F_IDLE);
endmodule

// File: rtl/eeprom3w_prog.sv
module eeprom3w_prog
  import eeprom3w_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              start_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o,
  output logic              wen_o,
  output logic              stat_o
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int TMR_W = $clog2(PROG_CYCLES + 1);

  logic [DATA_W-1:0] mem_q [WORDS];
  logic [TMR_W-1:0]  tmr_q;
  cmd_e              pcmd_q;
  logic [ADDR_W-1:0] paddr_q;
  logic [DATA_W-1:0] pdata_q;
  logic              accept, done;

  assign accept = cmd_valid_i & wen_o & ~busy_o & cmd_programs(cmd_i);
  assign done   = busy_o && (tmr_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_o   <= 1'b0;
      busy_o  <= 1'b0;
      stat_o  <= 1'b0;
      tmr_q   <= '0;
      pcmd_q  <= CMD_NONE;
      paddr_q <= '0;
      pdata_q <= '0;
    end else begin
      if (cmd_valid_i && cmd_i == CMD_WREN)  wen_o <= 1'b1;
      if (cmd_valid_i && cmd_i == CMD_WRDIS) wen_o <= 1'b0;
      if (start_i) stat_o <= 1'b0;
      if (accept) begin
        busy_o  <= 1'b1;
        stat_o  <= 1'b1;
        tmr_q   <= TMR_W'(PROG_CYCLES - 1);
        pcmd_q  <= cmd_i;
        paddr_q <= addr_i;
        pdata_q <= wdata_i;
      end else if (busy_o) begin
        if (done) busy_o <= 1'b0;
        else      tmr_q  <= tmr_q - 1'b1;
      end
    end
  end

  // Array changes only when the timed cycle ends
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic hit;
    assign hit = done && (((pcmd_q == CMD_WRITE || pcmd_q == CMD_ERASE) && paddr_q == ADDR_W'(w))
                          || pcmd_q == CMD_ERAL || pcmd_q == CMD_WRAL);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_q[w] <= '1;
      else if (hit) begin
        unique case (pcmd_q)
          CMD_WRITE: mem_q[w] <= pdata_q;
          CMD_WRAL:  mem_q[w] <= mem_q[w] & pdata_q;
          default:   mem_q[w] <= '1;
        endcase
      end
    end
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/eeprom3w.sv
module eeprom3w
  import eeprom3w_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o,
  output logic do_en_o
);
  logic              cs_s, sk_s, di_s;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;
  logic              start_p, cmd_valid, rd_drive, rd_bit, fr_idle;
  logic              busy, wen, stat;
  cmd_e              cmd;

  eeprom3w_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_i, sk_i, di_i}),
    .q_o   ({cs_s, sk_s, di_s})
  );

  eeprom3w_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_i       (cs_s),
    .sk_i       (sk_s),
    .di_i       (di_s),
    .busy_i     (busy),
    .rdata_i    (rdata),
    .addr_o     (addr),
    .start_o    (start_p),
    .cmd_valid_o(cmd_valid),
    .cmd_o      (cmd),
    .wdata_o    (wdata),
    .rd_drive_o (rd_drive),
    .rd_bit_o   (rd_bit),
    .idle_o     (fr_idle)
  );

  eeprom3w_prog #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_prog (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid),
    .cmd_i      (cmd),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .start_i    (start_p),
    .rdata_o    (rdata),
    .busy_o     (busy),
    .wen_o      (wen),
    .stat_o     (stat)
  );

  assign do_o    = rd_drive ? rd_bit : ~busy;
  assign do_en_o = cs_s & (rd_drive | stat);
endmodule

// File: rtl/eeprom3w_sva.sv
module eeprom3w_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_s,
  input logic busy,
  input logic stat,
  input logic wen,
  input logic start_p,
  input logic fr_idle,
  input logic do_o,
  input logic do_en_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_quiet_in_reset_R1: assert (!do_en_o && !busy && !wen);
    end
  end

  assert_locked_no_cycle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen |=> !$rose(busy));

  assert_busy_drives_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && stat && cs_s) |-> (do_en_o && !do_o));

  assert_hiz_when_deselected_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |-> !do_en_o);

  assert_deselect_aborts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_s |=> fr_idle);

  assert_no_start_when_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_p |-> !$past(busy));
endmodule

bind eeprom3w eeprom3w_sva u_sva (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_s   (cs_s),
  .busy   (busy),
  .stat   (stat),
  .wen    (wen),
  .start_p(start_p),
  .fr_idle(fr_idle),
  .do_o   (do_o),
  .do_en_o(do_en_o)
);

// File: tb/eeprom3w_test.sv
module eeprom3w_test;
  localparam int PROG = 300;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_v, do_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] model [64];

  always #5 clk = ~clk;

  eeprom3w #(.PROG_CYCLES(PROG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sk_i(sk), .di_i(di),
    .do_o(do_v), .do_en_o(do_en)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b);
    sk = 1'b0; di = b; wait_clk(HALF);
    sk = 1'b1;         wait_clk(HALF);
  endtask

  task automatic begin_frame();
    sk = 1'b0; di = 1'b0; cs = 1'b1; wait_clk(4);
  endtask

  task automatic end_frame();
    sk = 1'b0; di = 1'b0; wait_clk(4); cs = 1'b0; wait_clk(8);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [5:0] a);
    bitx(1'b1);
    for (int i = 1; i >= 0; i--) bitx(op[i]);
    for (int i = 5; i >= 0; i--) bitx(a[i]);
  endtask

  task automatic data16(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) bitx(d[i]);
  endtask

  task automatic wait_ready();
    wait_clk(PROG + 40);
  endtask

  task automatic short_cmd(input logic [1:0] op, input logic [5:0] a);
    begin_frame(); hdr(op, a); end_frame();
  endtask

  task automatic write_word(input logic [5:0] a, input logic [15:0] d);
    begin_frame(); hdr(2'b01, a); data16(d); end_frame();
  endtask

  task automatic read_word(input logic [5:0] a, output logic [15:0] w, output bit dummy_ok);
    begin_frame(); hdr(2'b10, a);
    dummy_ok = 1'b1;
    for (int j = 0; j <= 16; j++) begin
      sk = 1'b0; di = 1'b0; wait_clk(HALF);
      if (j == 0) dummy_ok = do_en && (do_v == 1'b0);
      else begin
        w[16-j] = do_v;
        if (!do_en) dummy_ok = 1'b0;
      end
      if (j < 16) begin sk = 1'b1; wait_clk(HALF); end
    end
    end_frame();
  endtask

  function automatic logic [15:0] and_merge(input logic [15:0] old, input logic [15:0] d);
    return old & d;
  endfunction

  task automatic check_word(input logic [5:0] a, input string req);
    logic [15:0] w; bit dz;
    read_word(a, w, dz);
    chk(w === model[a], req, {16'h0, w}, {16'h0, model[a]});
  endtask

  initial begin
    int seed;
    logic [15:0] w;
    bit dz;
    seed = 32'h5eed_0042;
    void'($urandom(seed));
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;

    wait_clk(5);
    chk(do_en === 1'b0, "R1 reset hi-z", {31'h0, do_en}, 32'h0);
    rst_n = 1'b1;
    wait_clk(5);
    chk(do_en === 1'b0, "R1 post-reset hi-z", {31'h0, do_en}, 32'h0);
    read_word(6'd0, w, dz);
    chk(w === 16'hFFFF, "R1 reset contents", {16'h0, w}, 32'hFFFF);
    chk(dz, "R3 dummy zero", {31'h0, dz}, 32'h1);

    // R2: data-in high with cs low, and zeros with cs high, start nothing
    cs = 1'b0;
    for (int i = 0; i < 4; i++) bitx(1'b1);
    chk(do_en === 1'b0, "R2 no frame with cs low", {31'h0, do_en}, 32'h0);
    begin_frame();
    for (int i = 0; i < 3; i++) bitx(1'b0);
    hdr(2'b10, 6'd1);
    sk = 1'b0; wait_clk(HALF);
    chk(do_en === 1'b1 && do_v === 1'b0, "R2 start after leading zeros", {30'h0, do_en, do_v}, 32'h2);
    end_frame();

    // R4: locked at power-up
    write_word(6'd2, 16'h0000);
    cs = 1'b1; wait_clk(8);
    chk(do_en === 1'b0, "R4 no busy while locked", {31'h0, do_en}, 32'h0);
    cs = 1'b0; wait_ready();
    short_cmd(2'b00, 6'b100000); wait_ready();
    check_word(6'd2, "R4 write ignored while locked");

    // R5 enable, R9 status, R6 write
    short_cmd(2'b00, 6'b110000);
    begin_frame(); hdr(2'b01, 6'd4); data16(16'hA5C3);
    sk = 1'b0;
    chk(do_en === 1'b1 && do_v === 1'b0, "R9 busy low", {30'h0, do_en, do_v}, 32'h2);
    wait_clk(PROG / 2);
    chk(do_en === 1'b1 && do_v === 1'b0, "R9 still busy", {30'h0, do_en, do_v}, 32'h2);
    wait_clk(PROG);
    chk(do_en === 1'b1 && do_v === 1'b1, "R9 ready high", {30'h0, do_en, do_v}, 32'h3);
    cs = 1'b0; wait_clk(6);
    chk(do_en === 1'b0, "R9 hi-z with cs low", {31'h0, do_en}, 32'h0);
    cs = 1'b1; wait_clk(6);
    chk(do_en === 1'b1 && do_v === 1'b1, "R9 ready after reselect", {30'h0, do_en, do_v}, 32'h3);
    cs = 1'b0; wait_clk(8);
    model[4] = 16'hA5C3;
    read_word(6'd4, w, dz);
    chk(w === 16'hA5C3, "R6 write read back", {16'h0, w}, 32'hA5C3);
    chk(dz, "R3 dummy zero on written word", {31'h0, dz}, 32'h1);

    // R6 overwrite clears and sets bits
    write_word(6'd4, 16'h5A3C); wait_ready(); model[4] = 16'h5A3C;
    check_word(6'd4, "R6 overwrite");

    // Random writes and reads, R3 and R6
    for (int n = 0; n < 16; n++) begin
      logic [5:0] a; logic [15:0] d;
      a = 6'($urandom()); d = 16'($urandom());
      write_word(a, d); wait_ready(); model[a] = d;
    end
    for (int n = 0; n < 16; n++) begin
      logic [5:0] a;
      a = 6'($urandom());
      check_word(a, "R3 random read");
    end

    // R7 erase word
    short_cmd(2'b11, 6'd4); wait_ready(); model[4] = 16'hFFFF;
    check_word(6'd4, "R7 erase word");

    // R11 trailing clocks after a complete write
    begin_frame(); hdr(2'b01, 6'd9); data16(16'h1234);
    for (int i = 0; i < 8; i++) bitx(1'b0);
    end_frame(); wait_ready(); model[9] = 16'h1234;
    check_word(6'd9, "R11 trailing clocks ignored");

    // R10 cs dropped mid-frame
    begin_frame(); hdr(2'b01, 6'd9); for (int i = 0; i < 5; i++) bitx(1'b0);
    end_frame(); wait_ready();
    check_word(6'd9, "R10 partial frame discarded");

    // R10 cs falls together with the final rising edge
    begin_frame(); hdr(2'b01, 6'd9);
    for (int i = 15; i > 0; i--) bitx(1'b0);
    sk = 1'b0; di = 1'b0; wait_clk(HALF);
    sk = 1'b1; cs = 1'b0; wait_clk(HALF);
    sk = 1'b0; wait_clk(4);
    cs = 1'b1; wait_clk(8);
    chk(do_en === 1'b0, "R10 same-cycle release no status", {31'h0, do_en}, 32'h0);
    cs = 1'b0; wait_ready();
    check_word(6'd9, "R10 same-cycle release discarded");

    // R12 frame during busy ignored
    write_word(6'd5, 16'h0F0F); model[5] = 16'h0F0F;
    short_cmd(2'b11, 6'd5);
    wait_ready();
    check_word(6'd5, "R12 erase during busy ignored");

    // R8 write-all ANDs into every word
    begin_frame(); hdr(2'b00, 6'b010000); data16(16'hFF00); end_frame(); wait_ready();
    for (int i = 0; i < 64; i++) model[i] = and_merge(model[i], 16'hFF00);
    check_word(6'd5, "R8 write-all and-merge");
    check_word(6'd63, "R8 write-all erased word");
    check_word(6'd9, "R8 write-all stored word");

    // R7 erase all
    short_cmd(2'b00, 6'b100000); wait_ready();
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    check_word(6'd5, "R7 erase-all");
    check_word(6'd9, "R7 erase-all");

    // R5 disable again
    short_cmd(2'b00, 6'b000000);
    write_word(6'd7, 16'h0001); wait_ready();
    check_word(6'd7, "R5 write after disable ignored");
    short_cmd(2'b11, 6'd7); wait_ready();
    check_word(6'd7, "R4 erase locked");

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule